// File: doc/BRIEF.md
# Constrained Counter Slot Allocator

This block hands out counter slots to incoming event codes. A bank of ten counters sits behind it. Some counters cannot count every event, so each 8-bit event code has a fixed mask of the counters allowed to count it. On a request the allocator takes the free counters from that mask and picks the one with the lowest index. It marks that counter as taken and returns its index one cycle later. If none of the allowed counters is free, the response reports failure and nothing changes.

A separate release port returns a counter to the free pool. The mask of taken counters is the block's only state, and reset clears all of it. The allocator places requests in arrival order, one at a time. It does not look ahead to serve the most constrained events first.

Top module: `ctr_slot_alloc`

## Requirements
- R1: Any event code not listed in R2 to R5 may be placed on counters 2 through 9 only. Counters 0 and 1 are never given to such a code.
- R2: Event code 0x02 may use counter 0 and counters 2 through 9. Event code 0x8c may use counters 1 and 7 only.
- R3: Event codes 0x8d, 0x8e, 0x8f, 0x90, 0x93, 0x94, 0x95, 0x98, 0x99, 0x9c, 0xbf, 0xc0, 0xc1, 0xc4, 0xc5, 0xc6, 0xc8, 0xca and 0xcb may use counters 5, 6 and 7 only.
- R4: Event codes 0x01, 0x96, 0x97, 0x9a, 0x9b and 0x9f may use counter 7 only.
- R5: Event codes 0xf5, 0xf6, 0xf7 and 0xfd may use counters 2, 4 and 6 only. Event code 0xf8 may use counters 2 through 7.
- R6: An accepted request gets the lowest-indexed counter that is both allowed and free. In the same step that counter becomes taken, so a later request cannot get it until it is released.
- R7: When no allowed counter is free, the response has ok low and index 0, and no counter changes state.
- R8: A release with an index from 0 to 9 frees that counter only. A release with an index of 10 or more has no effect.
- R9: rsp_valid is high exactly in the cycle after a cycle with req_valid high. rsp_ok and rsp_idx are valid in that same cycle.
- R10: When a release and a request arrive in the same cycle, the release takes effect first. The request may therefore be given the counter that is being released.
- R11: Releasing a counter that is already free has no effect. Reset frees every counter and holds rsp_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request an allocation this cycle |
| req_code | input | 8 | Event code to place |
| rel_valid | input | 1 | Release a counter this cycle |
| rel_idx | input | 4 | Index of the counter to release |
| rsp_valid | output | 1 | A response is present, one cycle after the request |
| rsp_ok | output | 1 | 1 = a counter was granted, 0 = no allowed counter was free |
| rsp_idx | output | 4 | Index of the granted counter (0 when rsp_ok is 0) |

## Verification
A wrong bit in the taken mask shows up at the next request whose mask covers that counter. A bit left set makes the allocator skip the counter or report failure too early. A bit lost lets two requests get the same index. The bench sweeps all 256 event codes. For each code it frees every counter, requests until the response fails, and compares every granted index and the point of failure with a model of its own. Any error in the mask lookup or in the lowest-index pick is therefore seen in the response one cycle after the request. Directed sequences cover a release and a request in the same cycle, double releases, out-of-range releases and reset.

// File: rtl/ctr_slot_alloc_pkg.sv
package ctr_slot_alloc_pkg;
  localparam int NUM_CTRS = 10;
  localparam int CODE_W   = 8;
  localparam int IDX_W    = $clog2(NUM_CTRS);

  typedef logic [NUM_CTRS-1:0] ctr_mask_t;

  // Counters each event code may occupy.
  function automatic ctr_mask_t allowed_ctrs(input logic [CODE_W-1:0] code);
    ctr_mask_t m;
    case (code)
      8'h02:                                   m = 10'b11_1111_1101;
      8'h8c:                                   m = 10'b00_1000_0010;
      8'h01, 8'h96, 8'h97, 8'h9a, 8'h9b, 8'h9f: m = 10'b00_1000_0000;
      8'hf5, 8'hf6, 8'hf7, 8'hfd:              m = 10'b00_0101_0100;
      8'hf8:                                   m = 10'b00_1111_1100;
      8'h8d, 8'h8e, 8'h8f, 8'h90, 8'h93, 8'h94, 8'h95, 8'h98, 8'h99,
      8'h9c, 8'hbf, 8'hc0, 8'hc1, 8'hc4, 8'hc5, 8'hc6, 8'hc8, 8'hca,
      8'hcb:                                   m = 10'b00_1110_0000;
      default:                                 m = 10'b11_1111_1100;
    endcase
    return m;
  endfunction

  // Index of the lowest set bit; 0 when the mask is empty.
  function automatic logic [IDX_W-1:0] lowest_index(input ctr_mask_t m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_CTRS - 1; i >= 0; i--)
      if (m[i]) r = IDX_W'(i);
    return r;
  endfunction
endpackage

// File: rtl/ctr_affinity_lut.sv
module ctr_affinity_lut
  import ctr_slot_alloc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output ctr_mask_t         allowed
);
  assign allowed = allowed_ctrs(code);
endmodule

// File: rtl/ctr_low_pick.sv
module ctr_low_pick
  import ctr_slot_alloc_pkg::*;
(
  input  ctr_mask_t        cand,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output ctr_mask_t        onehot
);
  assign found = |cand;
  assign idx   = lowest_index(cand);

  // Isolate the lowest set bit: a bit survives only if no lower bit is set.
  genvar g;
  generate
    for (g = 0; g < NUM_CTRS; g++) begin : g_iso
      if (g == 0) begin : g_first
        assign onehot[g] = cand[g];
      end else begin : g_rest
        assign onehot[g] = cand[g] && !(|cand[g-1:0]);
      end
    end
  endgenerate
endmodule

// File: rtl/ctr_slot_alloc.sv
module ctr_slot_alloc
  import ctr_slot_alloc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [7:0]       req_code,
  input  logic             rel_valid,
  input  logic [3:0]       rel_idx,
  output logic             rsp_valid,
  output logic             rsp_ok,
  output logic [3:0]       rsp_idx
);
  ctr_mask_t        used_q;
  ctr_mask_t        rel_vec;
  ctr_mask_t        used_eff;
  ctr_mask_t        allowed;
  ctr_mask_t        cand;
  ctr_mask_t        pick_vec;
  ctr_mask_t        grant_vec;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic             grant_any;
  logic             rel_in_range;

  assign rel_in_range = rel_valid && (rel_idx < 4'(NUM_CTRS));

  genvar g;
  generate
    for (g = 0; g < NUM_CTRS; g++) begin : g_rel
      assign rel_vec[g] = rel_valid && (rel_idx == 4'(g));
    end
  endgenerate

  // Release is applied before the request looks at the mask.
  assign used_eff = used_q & ~rel_vec;

  ctr_affinity_lut u_lut (
    .code    (req_code),
    .allowed (allowed)
  );

  assign cand = allowed & ~used_eff;

  ctr_low_pick u_pick (
    .cand   (cand),
    .found  (pick_found),
    .idx    (pick_idx),
    .onehot (pick_vec)
  );

  assign grant_any = req_valid && pick_found;
  assign grant_vec = req_valid ? pick_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_idx   <= '0;
    end else begin
      used_q    <= used_eff | grant_vec;
      rsp_valid <= req_valid;
      rsp_ok    <= grant_any;
      rsp_idx   <= grant_any ? 4'(pick_idx) : 4'd0;
    end
  end

  // Assertions
  assert_rsp_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_rsp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R1: a grant never lands outside the event's allowed counters.
  assert_grant_allowed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec & ~allowed) == '0);
  // R6: a grant only takes a counter that is free once the release is applied.
  assert_grant_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vec & used_eff) == '0);
  assert_grant_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_any |=> used_q[$past(pick_idx)]);
  // R7: a failed request with no release leaves the mask untouched.
  assert_fail_keeps_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !grant_any && !rel_valid) |=> used_q == $past(used_q));
  // R8: a release frees its counter unless the same-cycle request takes it again.
  assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_in_range && (grant_vec & rel_vec) == '0) |=> !used_q[$past(rel_idx)]);
  assert_rsp_ok_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> rsp_idx == 4'd0);
endmodule

// File: tb/ctr_slot_alloc_test.sv
module ctr_slot_alloc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_code = 8'h00;
  logic       rel_valid = 1'b0;
  logic [3:0] rel_idx = 4'd0;
  logic       rsp_valid, rsp_ok;
  logic [3:0] rsp_idx;

  int checks = 0;
  int fails  = 0;
  logic [9:0] model_used = '0;

  always #2 clk = ~clk;

  ctr_slot_alloc uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .rel_valid(rel_valid), .rel_idx(rel_idx),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_idx(rsp_idx)
  );

  // Allowed counters, built bit by bit from the requirement lists.
  function automatic logic [9:0] exp_mask(input logic [7:0] c);
    logic [9:0] m;
    m = 10'd0;
    if (c == 8'h02) begin
      m[0] = 1'b1;
      for (int k = 2; k <= 9; k++) m[k] = 1'b1;
    end else if (c == 8'h8c) begin
      m[1] = 1'b1; m[7] = 1'b1;
    end else if (c inside {8'h9f, 8'h9b, 8'h9a, 8'h97, 8'h96, 8'h01}) begin
      m[7] = 1'b1;
    end else if (c inside {8'hfd, 8'hf7, 8'hf6, 8'hf5}) begin
      for (int k = 2; k <= 6; k += 2) m[k] = 1'b1;
    end else if (c == 8'hf8) begin
      for (int k = 2; k <= 7; k++) m[k] = 1'b1;
    end else if (c inside {[8'h8d:8'h90], [8'h93:8'h95], 8'h98, 8'h99, 8'h9c,
                           [8'hbf:8'hc1], [8'hc4:8'hc6], 8'hc8, 8'hca, 8'hcb}) begin
      for (int k = 5; k <= 7; k++) m[k] = 1'b1;
    end else begin
      for (int k = 2; k <= 9; k++) m[k] = 1'b1;
    end
    return m;
  endfunction

  task automatic check(input logic cond, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, sample at the following negedge.
  task automatic step(input logic rq, input logic [7:0] code, input logic rl,
                      input logic [3:0] ridx, input string req);
    logic [9:0] eff, fr;
    int exp_idx;
    logic exp_ok;
    eff = model_used;
    if (rl && ridx < 10) eff[ridx] = 1'b0;
    fr = exp_mask(code) & ~eff;
    exp_ok = 1'b0; exp_idx = 0;
    for (int k = 9; k >= 0; k--) if (fr[k]) begin exp_ok = 1'b1; exp_idx = k; end
    req_valid = rq; req_code = code; rel_valid = rl; rel_idx = ridx;
    @(negedge clk);
    req_valid = 1'b0; rel_valid = 1'b0;
    check(rsp_valid == rq, "R9", "rsp_valid", int'(rsp_valid), int'(rq));
    if (rq) begin
      check(rsp_ok == exp_ok, req, "rsp_ok", int'(rsp_ok), int'(exp_ok));
      check(int'(rsp_idx) == exp_idx, req, "rsp_idx", int'(rsp_idx), exp_idx);
      if (exp_ok) eff[exp_idx] = 1'b1;
    end
    model_used = eff;
  endtask

  function automatic string tag_of(input logic [7:0] c);
    if (c == 8'h02 || c == 8'h8c) return "R2";
    if (c inside {8'h01, 8'h96, 8'h97, 8'h9a, 8'h9b, 8'h9f}) return "R4";
    if (c inside {8'hf5, 8'hf6, 8'hf7, 8'hf8, 8'hfd}) return "R5";
    if (exp_mask(c) == 10'b00_1110_0000) return "R3";
    return "R1";
  endfunction

  initial begin
    #(4ns * 200000);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset holds rsp_valid low
    check(rsp_valid == 1'b0, "R11", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11", "rsp_valid after reset", int'(rsp_valid), 0);

    // Sweep all codes: fill until failure (R1..R7), then free everything (R8)
    for (int c = 0; c < 256; c++) begin
      for (int k = 0; k <= $countones(exp_mask(8'(c))); k++)
        step(1'b1, 8'(c), 1'b0, 4'd0, tag_of(8'(c)));
      step(1'b1, 8'(c), 1'b0, 4'd0, "R7");
      for (int k = 0; k < 10; k++) step(1'b0, 8'h00, 1'b1, 4'(k), "R8");
    end

    // Fill counters 2..9 with a default code, then probe releases
    for (int k = 0; k < 8; k++) step(1'b1, 8'h33, 1'b0, 4'd0, "R6");
    step(1'b0, 8'h00, 1'b1, 4'd12, "R8");            // out of range: no effect
    step(1'b1, 8'h33, 1'b0, 4'd0, "R8");             // still full -> fail
    step(1'b0, 8'h00, 1'b1, 4'd5, "R8");
    step(1'b0, 8'h00, 1'b1, 4'd5, "R11");            // already free
    step(1'b0, 8'h00, 1'b1, 4'd0, "R11");            // counter 0 free: no effect
    step(1'b1, 8'h33, 1'b0, 4'd0, "R8");             // gets 5
    step(1'b1, 8'h33, 1'b0, 4'd0, "R11");            // fails again
    step(1'b1, 8'h02, 1'b0, 4'd0, "R2");             // counter 0
    // R10: release 7 while requesting a counter-7-only event
    step(1'b1, 8'h9f, 1'b1, 4'd7, "R10");
    step(1'b1, 8'h9f, 1'b0, 4'd0, "R10");            // 7 taken again -> fail
    step(1'b1, 8'h8c, 1'b1, 4'd7, "R10");            // counter 1 lower than 7
    step(1'b1, 8'hf5, 1'b1, 4'd4, "R10");            // gets 4
    step(1'b0, 8'h00, 1'b0, 4'd0, "R9");

    // R11: reset frees everything
    rst_n = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    model_used = '0;
    step(1'b1, 8'h01, 1'b0, 4'd0, "R11");            // counter 7 free again
    step(1'b1, 8'h02, 1'b0, 4'd0, "R11");            // counter 0 free again

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule